// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a synchronous four-beat burst to a memory. A load happens when either of two independent address strobes is high at a clock edge. The full external address is then captured. While no strobe is high, each cycle with the advance input high moves the burst on by one beat. Only the two lowest address bits change during a burst. The bits above them stay at the loaded value.

A static order input picks how the low two bits move. In linear order they count upward from the start offset and wrap modulo four. In interleaved order the start offset is XORed with a beat count that runs 0,1,2,3. A load may be issued on any cycle, so the block can also take a fresh address every cycle without bursting at all.

The same block also decodes the write controls into one enable per byte lane. A global write enables every lane, whatever the byte controls say. Otherwise, a byte-write enable combined with the per-lane selects enables only the selected lanes. The lane enables are registered, so they line up with the address of the same cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `addr_out` is 0 and `lane_we` is all zeros.
- R2: When `strobe_a` is high at an edge, `addr_out` equals the `addr_in` sampled at that edge, and the beat count restarts at 0.
- R3: When `strobe_b` is high at an edge, it loads the address exactly as `strobe_a` does.
- R4: With neither strobe high and `adv` low, `addr_out` holds its value across the edge.
- R5: With `order_lin` = 1 (linear), beat n of a burst has low bits (start + n) mod 4. Example: start 1 gives 1,2,3,0.
- R6: With `order_lin` = 0 (interleaved, the tied-low default), beat n has low bits start XOR (n mod 4). Example: start 1 gives 1,0,3,2.
- R7: When a strobe and `adv` are high together, the load wins. `addr_out` becomes `addr_in` and the beat count restarts at 0.
- R8: Bits `addr_out[ADDR_W-1:2]` change only on a load.
- R9: When `glob_wr` is high at an edge, `lane_we` is all ones after that edge, whatever `byte_wr_en` and `byte_sel` are.
- R10: When `glob_wr` is low at an edge, `lane_we` equals `byte_sel` if `byte_wr_en` was high, and all zeros otherwise.
- R11: Loads on consecutive cycles each take effect at once, with no stall cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_a | input | 1 | First address strobe; loads `addr_in` |
| strobe_b | input | 1 | Second address strobe; loads `addr_in` |
| adv | input | 1 | Step the burst by one beat |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_in | input | ADDR_W | External start address |
| glob_wr | input | 1 | Enable all byte lanes |
| byte_wr_en | input | 1 | Qualifies `byte_sel` |
| byte_sel | input | LANES | Per-lane byte select |
| addr_out | output | ADDR_W | Current burst address |
| lane_we | output | LANES | Registered per-lane write enables |

## Verification
The assertions check on every cycle that a load captures the input address and takes priority over an advance. They also check that the address holds when the block is idle, that the upper bits stay fixed between loads, that one linear step adds one modulo four, and that the lane mask follows the write controls. Some behaviour shows up only across a whole burst: the interleaved XOR pattern, the full four-beat sequence for every start offset in both orders, and wrap-around after the fourth beat. The bench's scenarios cover these by comparing the outputs with its reference model on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_INC = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int HI_W = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [HI_W-1:0]   hi_q,
  output beat_t             start_q,
  output beat_t             beat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      hi_q    <= addr_in[ADDR_W-1:BEAT_W];
      start_q <= addr_in[BEAT_W-1:0];
      beat_q  <= '0;
    end else if (adv) begin
      beat_q  <= beat_q + beat_t'(1);
    end
  end
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_seq_pkg::*;
(
  input  logic  order_lin,
  input  beat_t start,
  input  beat_t beat,
  output beat_t offset
);
  burst_order_e ord;
  assign ord = burst_order_e'(order_lin);

  always_comb begin
    unique case (ord)
      ORD_INC: offset = start + beat;
      default: offset = start ^ beat;
    endcase
  end
endmodule

// File: rtl/wr_lane_dec.sv
module wr_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glob_wr,
  input  logic             byte_wr_en,
  input  logic [LANES-1:0] byte_sel,
  output logic [LANES-1:0] lane_we
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_we[g] <= 1'b0;
      else     lane_we[g] <= glob_wr | (byte_wr_en & byte_sel[g]);
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              adv,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              glob_wr,
  input  logic              byte_wr_en,
  input  logic [LANES-1:0]  byte_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic [LANES-1:0]  lane_we
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0] hi_q;
  beat_t           start_q;
  beat_t           beat_q;
  beat_t           offset;
  logic            load;

  assign load = strobe_a | strobe_b;

  burst_beat_ctr #(.ADDR_W(ADDR_W)) ctr_i (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .addr_in(addr_in),
    .hi_q(hi_q), .start_q(start_q), .beat_q(beat_q)
  );

  burst_offset_map map_i (
    .order_lin(order_lin), .start(start_q), .beat(beat_q), .offset(offset)
  );

  wr_lane_dec #(.LANES(LANES)) lane_i (
    .clk(clk), .rst(rst), .glob_wr(glob_wr), .byte_wr_en(byte_wr_en),
    .byte_sel(byte_sel), .lane_we(lane_we)
  );

  assign addr_out = {hi_q, offset};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_a,
  input logic              strobe_b,
  input logic              adv,
  input logic              order_lin,
  input logic [ADDR_W-1:0] addr_in,
  input logic              glob_wr,
  input logic              byte_wr_en,
  input logic [LANES-1:0]  byte_sel,
  input logic [ADDR_W-1:0] addr_out,
  input logic [LANES-1:0]  lane_we
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (addr_out == '0 && lane_we == '0)); // R1
  AST_LOAD_A: assert property (@(posedge clk) disable iff (rst) strobe_a |=> addr_out == $past(addr_in)); // R2
  AST_LOAD_B: assert property (@(posedge clk) disable iff (rst) strobe_b |=> addr_out == $past(addr_in)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobe_a && !strobe_b && !adv && $stable(order_lin)) |=> (order_lin != $past(order_lin)) || $stable(addr_out)); // R4
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (order_lin && adv && !strobe_a && !strobe_b) |=> (!order_lin || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ((strobe_a || strobe_b) && adv) |=> addr_out == $past(addr_in)); // R7
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!strobe_a && !strobe_b) |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])); // R8
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (rst) glob_wr |=> (&lane_we)); // R9
  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (rst)
    !glob_wr |=> lane_we == ($past(byte_wr_en) ? $past(byte_sel) : '0)); // R10
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b), .adv(adv),
  .order_lin(order_lin), .addr_in(addr_in), .glob_wr(glob_wr),
  .byte_wr_en(byte_wr_en), .byte_sel(byte_sel), .addr_out(addr_out),
  .lane_we(lane_we)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 20;
  localparam int LANES  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              strobe_a = 0, strobe_b = 0, adv = 0, order_lin = 0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              glob_wr = 0, byte_wr_en = 0;
  logic [LANES-1:0]  byte_sel = '0;
  logic [ADDR_W-1:0] addr_out;
  logic [LANES-1:0]  lane_we;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference state
  int m_hi = 0, m_start = 0, m_beat = 0, m_lanes = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b), .adv(adv),
    .order_lin(order_lin), .addr_in(addr_in), .glob_wr(glob_wr),
    .byte_wr_en(byte_wr_en), .byte_sel(byte_sel), .addr_out(addr_out),
    .lane_we(lane_we)
  );

  function automatic int exp_addr();
    int low;
    low = order_lin ? (m_start + m_beat) % 4 : (m_start ^ m_beat);
    return (m_hi * 4) + low;
  endfunction

  task automatic cyc(input bit sa, input bit sb, input bit av, input int a,
                     input bit gw, input bit bwe, input int bs, input string req);
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0]  el;
    strobe_a = sa; strobe_b = sb; adv = av; addr_in = ADDR_W'(a);
    glob_wr = gw; byte_wr_en = bwe; byte_sel = LANES'(bs);
    @(posedge clk);
    if (rst) begin
      m_hi = 0; m_start = 0; m_beat = 0; m_lanes = 0;
    end else begin
      if (sa || sb) begin
        m_hi = a / 4; m_start = a % 4; m_beat = 0;
      end else if (av) begin
        m_beat = (m_beat + 1) % 4;
      end
      m_lanes = gw ? ((1 << LANES) - 1) : (bwe ? bs : 0);
    end
    @(negedge clk);
    ea = ADDR_W'(exp_addr());
    el = LANES'(m_lanes);
    checks++;
    if (addr_out !== ea || lane_we !== el) begin
      errors++;
      $display("FAIL %s: addr_out=%h lane_we=%b expected addr_out=%h lane_we=%b",
               req, addr_out, lane_we, ea, el);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset clears address and lanes, even with inputs active
    cyc(1, 0, 1, 32'h5A5A7, 1, 1, 4'hF, "R1");
    cyc(0, 0, 0, 0, 0, 0, 0, "R1");
    rst = 1'b0;

    // R2 R3 R4 R5 R6 R8: all start offsets in both orders
    for (int ord = 0; ord < 2; ord++) begin
      order_lin = ord[0];
      for (int s = 0; s < 4; s++) begin
        int base = (32'h3C5A0 + s * 32'h1104) & ~3;
        if (s % 2 == 0) cyc(1, 0, 0, base + s, 0, 0, 0, "R2");
        else            cyc(0, 1, 0, base + s, 0, 0, 0, "R3");
        for (int n = 0; n < 6; n++) begin
          cyc(0, 0, 1, 32'hFFFFF, 0, 0, 0, ord ? "R5" : "R6");
          if (n == 2) cyc(0, 0, 0, 32'h12345, 0, 0, 0, "R4");
        end
        cyc(0, 0, 1, 0, 0, 0, 0, "R8");
      end
    end

    // R7: load together with advance, then step from beat 0
    order_lin = 1'b1;
    cyc(1, 0, 0, 32'h00002, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, 0, 0, "R5");
    cyc(0, 1, 1, 32'hABCD1, 0, 0, 0, "R7");
    cyc(0, 0, 1, 0, 0, 0, 0, "R7");
    order_lin = 1'b0;
    cyc(1, 1, 1, 32'h76543, 0, 0, 0, "R7");
    cyc(0, 0, 1, 0, 0, 0, 0, "R6");

    // R11: a fresh load on every cycle
    for (int k = 0; k < 8; k++)
      cyc(k[0], !k[0], k[1], 32'h10000 + k * 32'h2F3D, 0, 0, 0, "R11");

    // R9 R10: every combination of the write controls
    for (int gw = 0; gw < 2; gw++)
      for (int bwe = 0; bwe < 2; bwe++)
        for (int bs = 0; bs < 16; bs++)
          cyc(0, 0, bs[0], 0, gw[0], bwe[0], bs, gw ? "R9" : "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, "R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule